// File: doc/BRIEF.md
# Register File with Mirrored Operand Bank

This block is the general-purpose register file of a single-issue, in-order embedded core. It adds a small bank of three mirror registers that only custom-instruction logic can read. Basic instructions use the core array through two combinational read ports and one write port. Every write-back also carries a 2-bit mirror code. That code either copies the same result into one of the mirror registers or skips the copy. The core write always proceeds as usual in the same cycle.

An extended instruction reads its two core operands through the normal read ports. In the same cycle it takes further operands from the mirror bank through one or more mirror read ports. A three-input custom operation therefore issues in one cycle, with no extra move to stage the third operand. A mirror read that hits the entry being written in that cycle returns the incoming value.

Top module: `mirror_regfile`

## Requirements
- R1: While reset is asserted and after it is released, every core register and every mirror register reads as zero.
- R2: With `wrEn` high, `wrData` is stored in core register `wrAddr` at the clock edge. Both core read ports are combinational and show the stored value from the next cycle. A read in the write cycle itself returns the previous contents.
- R3: Core register 0 always reads as zero on both ports, and writes addressed to it are discarded.
- R4: A write with mirror code 2'b00, 2'b01 or 2'b10 also stores `wrData` into mirror register 0, 1 or 2 respectively, at the same edge as the core write.
- R5: A write with mirror code 2'b11 leaves all three mirror registers unchanged, while the core write still takes place.
- R6: With `wrEn` low, neither the core array nor the mirror bank changes, whatever the mirror code.
- R7: A mirror read port with select 0, 1 or 2 returns that mirror register with its invalid flag low. Select 2'b11 returns zero with the flag high.
- R8: A mirror read port whose select matches the mirror register being written in the same cycle returns `wrData` combinationally.
- R9: The core read ports never return mirror contents. They always return the core register addressed.
- R10: The mirror read ports are independent. Port p uses select bits [2p+1:2p] and data bits [DATA_W*(p+1)-1:DATA_W*p], and different ports may read different entries in the same cycle.
- R11: A write addressed to core register 0 with a mirror code of 0 to 2 still updates the selected mirror register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write-back valid |
| wrAddr | input | ADDR_W | Core destination register |
| wrData | input | DATA_W | Result being written back |
| wrShadowSel | input | 2 | Mirror code: 00/01/10 copy to mirror 0/1/2, 11 skip |
| rdAddrA | input | ADDR_W | Core read port A address |
| rdDataA | output | DATA_W | Core read port A data |
| rdAddrB | input | ADDR_W | Core read port B address |
| rdDataB | output | DATA_W | Core read port B data |
| shRdSel | input | 2*SH_PORTS | Mirror read selects, 2 bits per port |
| shRdData | output | DATA_W*SH_PORTS | Mirror read data, one word per port |
| shRdInvalid | output | SH_PORTS | High when a port's select is 11 |

## Verification
The bench builds the block with 32-bit data, 32 core registers and two mirror read ports. Two ports let every check read two different mirror entries in the same cycle, and let one port see a forwarded value while the other still sees stored contents. With 32 registers the bench can sweep every core address after a mirror-only write, which shows that no core read returns mirror contents. The vector table mixes the three copy codes with the skip code and with writes to register 0.

// File: rtl/mirror_rf_pkg.sv
package mirror_rf_pkg;
  localparam int SEL_W      = 2;
  localparam int SHADOW_CNT = 3;

  typedef logic [SEL_W-1:0] shSel_t;
  localparam shSel_t SEL_SKIP = 2'b11;

  // Strobes handed from the control to the datapath
  typedef struct packed {
    logic                  coreWe;
    logic [SHADOW_CNT-1:0] shadowWe;
  } wrStrobe_t;
endpackage

// File: rtl/mirror_rf_ctrl.sv
module mirror_rf_ctrl
  import mirror_rf_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  shSel_t            wrShadowSel,
  output wrStrobe_t         strobe
);
  always_comb begin
    strobe.coreWe = wrEn && (wrAddr != '0);
    for (int k = 0; k < SHADOW_CNT; k++) begin
      strobe.shadowWe[k] = wrEn && (wrShadowSel == shSel_t'(k));
    end
  end
endmodule

// File: rtl/mirror_rf_dp.sv
module mirror_rf_dp
  import mirror_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int ADDR_W   = 5,
  parameter int SH_PORTS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  wrStrobe_t                  strobe,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]          rdAddrA,
  output logic [DATA_W-1:0]          rdDataA,
  input  logic [ADDR_W-1:0]          rdAddrB,
  output logic [DATA_W-1:0]          rdDataB,
  input  logic [SEL_W*SH_PORTS-1:0]  shRdSel,
  output logic [DATA_W*SH_PORTS-1:0] shRdData,
  output logic [SH_PORTS-1:0]        shRdInvalid
);
  logic [DATA_W-1:0] coreQ [NUM_REGS];
  logic [DATA_W-1:0] shQ   [SHADOW_CNT];

  // Core array: entry 0 is never written (coreWe excludes it)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) coreQ[i] <= '0;
    end else if (strobe.coreWe) begin
      coreQ[wrAddr] <= wrData;
    end
  end

  always_comb begin
    rdDataA = (rdAddrA == '0) ? '0 : coreQ[rdAddrA];
    rdDataB = (rdAddrB == '0) ? '0 : coreQ[rdAddrB];
  end

  // Mirror bank
  for (genvar g = 0; g < SHADOW_CNT; g++) begin : gShadow
    always_ff @(posedge clk) begin
      if (!rst_n)                 shQ[g] <= '0;
      else if (strobe.shadowWe[g]) shQ[g] <= wrData;
    end
  end

  // Mirror read ports with same-cycle forwarding
  for (genvar p = 0; p < SH_PORTS; p++) begin : gShPort
    shSel_t            portSel;
    logic [DATA_W-1:0] portData;
    assign portSel = shRdSel[p*SEL_W +: SEL_W];

    always_comb begin
      portData = '0;
      for (int k = 0; k < SHADOW_CNT; k++) begin
        if (portSel == shSel_t'(k)) begin
          portData = strobe.shadowWe[k] ? wrData : shQ[k];
        end
      end
    end

    assign shRdData[p*DATA_W +: DATA_W] = portData;
    assign shRdInvalid[p]               = (portSel == SEL_SKIP);
  end
endmodule

// File: rtl/mirror_regfile.sv
module mirror_regfile
  import mirror_rf_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 32,
  parameter int SH_PORTS = 2,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [1:0]                 wrShadowSel,
  input  logic [ADDR_W-1:0]          rdAddrA,
  output logic [DATA_W-1:0]          rdDataA,
  input  logic [ADDR_W-1:0]          rdAddrB,
  output logic [DATA_W-1:0]          rdDataB,
  input  logic [2*SH_PORTS-1:0]      shRdSel,
  output logic [DATA_W*SH_PORTS-1:0] shRdData,
  output logic [SH_PORTS-1:0]        shRdInvalid
);
  wrStrobe_t strobe;

  mirror_rf_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrShadowSel (wrShadowSel),
    .strobe      (strobe)
  );

  mirror_rf_dp #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .SH_PORTS (SH_PORTS)
  ) uDp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .rdAddrA     (rdAddrA),
    .rdDataA     (rdDataA),
    .rdAddrB     (rdAddrB),
    .rdDataB     (rdDataB),
    .shRdSel     (shRdSel),
    .shRdData    (shRdData),
    .shRdInvalid (shRdInvalid)
  );
endmodule

// File: rtl/mirror_regfile_chk.sv
module mirror_regfile_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int SH_PORTS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [DATA_W-1:0]          wrData,
  input logic [1:0]                 wrShadowSel,
  input logic [ADDR_W-1:0]          rdAddrA,
  input logic [DATA_W-1:0]          rdDataA,
  input logic [2*SH_PORTS-1:0]      shRdSel,
  input logic [DATA_W*SH_PORTS-1:0] shRdData,
  input logic [SH_PORTS-1:0]        shRdInvalid
);
  logic [1:0]        sel0;
  logic [DATA_W-1:0] data0;
  assign sel0  = shRdSel[1:0];
  assign data0 = shRdData[DATA_W-1:0];

  a_r3_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddrA == '0) |-> (rdDataA == '0));

  a_r2_core_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrEn) && $past(wrAddr) != '0 && rdAddrA == $past(wrAddr))
      |-> (rdDataA == $past(wrData)));

  a_r4_mirror_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrEn) && $past(wrShadowSel) != 2'b11 && sel0 == $past(wrShadowSel)
     && !(wrEn && wrShadowSel == sel0))
      |-> (data0 == $past(wrData)));

  a_r5_skip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wrEn) && $past(wrShadowSel) == 2'b11 && sel0 == $past(sel0)
     && sel0 != 2'b11 && !(wrEn && wrShadowSel == sel0))
      |-> (data0 == $past(data0)));

  a_r8_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrShadowSel != 2'b11 && sel0 == wrShadowSel) |-> (data0 == wrData));

  for (genvar p = 0; p < SH_PORTS; p++) begin : gPortChk
    a_r7_skip_code: assert property (@(posedge clk) disable iff (!rst_n)
      (shRdSel[2*p +: 2] == 2'b11)
        |-> (shRdInvalid[p] && shRdData[p*DATA_W +: DATA_W] == '0));
    a_r7_valid_code: assert property (@(posedge clk) disable iff (!rst_n)
      (shRdSel[2*p +: 2] != 2'b11) |-> !shRdInvalid[p]);
  end
endmodule

bind mirror_regfile mirror_regfile_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .SH_PORTS (SH_PORTS)
) uChk (.*);

// File: tb/tb_mirror_regfile.sv
`timescale 1ns/1ps
module tb_mirror_regfile;
  localparam int DW = 32;
  localparam int NR = 32;
  localparam int AW = 5;
  localparam int SP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [1:0]    wrShadowSel = 2'b11;
  logic [AW-1:0] rdAddrA = '0, rdAddrB = '0;
  logic [DW-1:0] rdDataA, rdDataB;
  logic [2*SP-1:0]  shRdSel = '0;
  logic [DW*SP-1:0] shRdData;
  logic [SP-1:0]    shRdInvalid;

  int errs = 0;
  int total = 0;
  logic [DW-1:0] coreM [NR];
  logic [DW-1:0] shM [3];

  always #4 clk = ~clk;

  mirror_regfile #(.DATA_W(DW), .NUM_REGS(NR), .SH_PORTS(SP)) dut (.*);

  // {addr, data, mirror code}
  localparam logic [38:0] VEC [8] = '{
    {5'd5,  32'h1111_0005, 2'b00},
    {5'd9,  32'hA5A5_0009, 2'b01},
    {5'd31, 32'hFFFF_001F, 2'b10},
    {5'd12, 32'h0000_00CC, 2'b11},
    {5'd0,  32'hDEAD_0000, 2'b01},
    {5'd5,  32'h5555_0505, 2'b11},
    {5'd17, 32'h8000_0011, 2'b00},
    {5'd9,  32'h0BAD_F00D, 2'b10}
  };

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkCore(input string tag, input int a);
    rdAddrA = AW'(a); rdAddrB = AW'(a); #1;
    chk(tag, rdDataA, coreM[a]);
    chk(tag, rdDataB, coreM[a]);
  endtask

  // R10: both mirror ports read different entries in one cycle
  task automatic checkMirror(input string tag);
    for (int k = 0; k < 3; k++) begin
      shRdSel = {2'(2 - k), 2'(k)}; #1;
      chk(tag, shRdData[DW-1:0], shM[k]);
      chk({tag, "/R10"}, shRdData[2*DW-1:DW], shM[2-k]);
      chk("R7 flag", {30'd0, shRdInvalid}, 32'd0);
    end
  endtask

  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] s);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; wrShadowSel = s;
    @(negedge clk);
    wrEn = 1'b0; wrShadowSel = 2'b11;
    if (a != 0) coreM[a] = d;
    if (s != 2'b11) shM[s] = d;
  endtask

  initial begin
    for (int i = 0; i < NR; i++) coreM[i] = '0;
    for (int k = 0; k < 3; k++) shM[k] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values, during and after reset
    checkCore("R1", 7);
    checkMirror("R1");
    rst_n = 1'b1;
    @(negedge clk);
    checkCore("R1", 31);
    checkMirror("R1");

    for (int v = 0; v < 8; v++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      logic [1:0] s;
      {a, d, s} = VEC[v];
      doWrite(a, d, s);
      if (a == 0) checkCore("R3", 0);
      else        checkCore("R2", int'(a));
      if (s == 2'b11)    checkMirror("R5");
      else if (a == 0)   checkMirror("R11");
      else               checkMirror("R4");
      if (a == 0) begin
        // R9: mirror holds DEAD0000, no core address may return it
        for (int i = 0; i < NR; i++) checkCore("R9", i);
      end
    end

    // R8: forwarding, plus R2 same-cycle core read returns old contents
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 5'd3; wrData = 32'h0F0F_7777; wrShadowSel = 2'b10;
    shRdSel = {2'd1, 2'd2}; rdAddrA = 5'd3; #1;
    chk("R8", shRdData[DW-1:0], 32'h0F0F_7777);
    chk("R8 other port", shRdData[2*DW-1:DW], shM[1]);
    chk("R2 same cycle", rdDataA, coreM[3]);
    @(negedge clk);
    wrEn = 1'b0; wrShadowSel = 2'b11;
    coreM[3] = 32'h0F0F_7777; shM[2] = 32'h0F0F_7777;
    checkCore("R2", 3);
    checkMirror("R4");

    // R6: strobes with wrEn low do nothing
    @(negedge clk);
    wrAddr = 5'd4; wrData = 32'hBBBB_BBBB; wrShadowSel = 2'b00;
    @(negedge clk);
    wrShadowSel = 2'b01;
    @(negedge clk);
    wrShadowSel = 2'b11;
    checkCore("R6", 4);
    checkMirror("R6");

    // R7: skip select on both ports
    shRdSel = 4'b1111; #1;
    chk("R7 data", shRdData[DW-1:0], '0);
    chk("R7 data", shRdData[2*DW-1:DW], '0);
    chk("R7 flag", {30'd0, shRdInvalid}, 32'd3);
    shRdSel = 4'b1100; #1;
    chk("R7 mixed", {30'd0, shRdInvalid}, 32'd2);
    chk("R7 mixed data", shRdData[DW-1:0], shM[0]);

    // R1: reset clears everything again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NR; i++) coreM[i] = '0;
    for (int k = 0; k < 3; k++) shM[k] = '0;
    checkCore("R1", 17);
    checkCore("R1", 9);
    checkMirror("R1");

    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule